// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Programming Lock

This block sits between a CPU register bus and a small array of one-time-programmable fuse rows. Software picks an operation code, a row index and up to two words of write data, then raises a start bit. The controller runs the operation over a fixed number of busy cycles and reports its progress in a status word. Read results are captured into read-data registers. Programming stays locked until software has fed a fixed four-value key through the unlock operation.

The fuse array is modelled as flops that can only gain ones. A program operation ORs its data into the addressed row, so a bit that has been fused stays at 1. The `ROW_WORDS` parameter selects one-word or two-word rows. In one-word mode the second read-data and write-data locations read as zero and ignore writes.

The command state machine has five states. `ST_IDLE` waits for a launch. A launch moves it to `ST_RD_WAIT` for a read, to `ST_PG_WAIT` for a program, or to `ST_CTL_WAIT` for any other code. Each wait state counts its latency down and then moves to `ST_FINISH`. `ST_FINISH` applies the effect of the operation (capturing read data, ORing into a fuse row, advancing or resetting the key checker, or relocking), sets command-done, and returns to `ST_IDLE`.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the status word, the start register, the operation register and both read-data registers read 0, and every fuse row reads back as 0.
- R2: Bit 0 of the access register (byte offset 0x00) enables launches. While this bit is 0, raising the start bit does not start an operation, and the status stays 0.
- R3: The status word (0x0C) holds busy in bit 0, command-done in bit 1 and program-ok in bit 2. A launch happens only when a write to the start register (0x08) takes its bit 0 from 0 to 1 while the controller is idle. Writing 1 again while the bit is already 1 does nothing. Writing 0 clears command-done.
- R4: The operation register (0x04) keeps only its low 6 bits, and the row-address register (0x28) keeps only its low 16 bits. Both read back masked.
- R5: Operation code 0x0 reads the addressed row. Command-done is visible READ_CYCLES+1 clock edges after the launching write. The row's low word then appears at 0x10 and, with two-word rows, its high word appears at 0x5C.
- R6: Operation code 0x2 is one unlock step, with its key value taken from write-data word 0 (0x2C). Four steps in a row with values 0xF, 0x4, 0x8 and 0xD unlock programming and set program-ok. The first three steps leave program-ok clear. Each step completes 2 edges after launch.
- R7: A key value that does not match the expected step sends the checker back to its first step. A later partial sequence then does not unlock.
- R8: A program operation (0x8) issued while locked completes with command-done set and program-ok clear, and the fuse row is left unchanged.
- R9: An unlocked program operation ORs write-data word 0 (0x2C) and, with two-word rows, word 1 (0x64) into the addressed row. Bits that are already 1 are never cleared.
- R10: A program operation keeps busy set and command-done clear until exactly PROG_CYCLES+1 edges after the launching write.
- R11: Operation code 0x3 relocks programming and sets program-ok when it completes. Later program operations are then rejected as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest situation to reach is a key sequence that goes wrong part-way through. The checker must forget its progress, and the value that was rejected must not count as a new first step. The bench feeds two correct values, one wrong value and then the last two correct values. It then confirms that program-ok stays clear and that a program operation still leaves the row blank. Only after that does it run the clean sequence and check program-ok step by step. It then proves OR-only fusing by programming the same row twice with disjoint bit patterns.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;
    localparam int WORD_W  = 32;
    localparam int REG_AW  = 8;
    localparam int OP_W    = 6;
    localparam int ROWA_W  = 16;
    localparam int STAT_W  = 3;

    localparam logic [REG_AW-1:0] OFF_ACCESS = 8'h00;
    localparam logic [REG_AW-1:0] OFF_OP     = 8'h04;
    localparam logic [REG_AW-1:0] OFF_START  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_STATUS = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_RDW0   = 8'h10;
    localparam logic [REG_AW-1:0] OFF_ROWSEL = 8'h28;
    localparam logic [REG_AW-1:0] OFF_WRW0   = 8'h2C;
    localparam logic [REG_AW-1:0] OFF_RDW1   = 8'h5C;
    localparam logic [REG_AW-1:0] OFF_WRW1   = 8'h64;

    localparam logic [OP_W-1:0] OP_READ    = 6'h00;
    localparam logic [OP_W-1:0] OP_UNLOCK  = 6'h02;
    localparam logic [OP_W-1:0] OP_RELOCK  = 6'h03;
    localparam logic [OP_W-1:0] OP_PROGRAM = 6'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_PG_WAIT,
        ST_CTL_WAIT,
        ST_FINISH
    } fsm_state_t;

    function automatic logic [WORD_W-1:0] unlock_key(input logic [1:0] idx);
        case (idx)
            2'd0:    return 32'h0000_000F;
            2'd1:    return 32'h0000_0004;
            2'd2:    return 32'h0000_0008;
            default: return 32'h0000_000D;
        endcase
    endfunction

    function automatic logic [REG_AW-1:0] wr_word_off(input int w);
        return (w == 0) ? OFF_WRW0 : OFF_WRW1;
    endfunction
endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
    import otp_ctrl_pkg::*;
#(
    parameter int ROW_WORDS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_AW-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    input  logic                        fsm_idle,
    input  logic [STAT_W-1:0]           status,
    input  logic [ROW_WORDS*WORD_W-1:0] rd_row,
    output logic                        access_en,
    output logic                        launch,
    output logic                        clr_done,
    output logic [OP_W-1:0]             op_code,
    output logic [ROWA_W-1:0]           row_addr,
    output logic [ROW_WORDS*WORD_W-1:0] wr_row
);
    localparam int ROW_BITS = ROW_WORDS * WORD_W;

    logic                mode_q;
    logic                start_q;
    logic [OP_W-1:0]     op_q;
    logic [ROWA_W-1:0]   rowsel_q;
    logic [ROW_BITS-1:0] wd_q;
    logic [2*WORD_W-1:0] rd_ext;
    logic [2*WORD_W-1:0] wd_ext;
    logic                start_wr;

    assign start_wr = bus_wr && (bus_addr == OFF_START);
    assign launch   = start_wr && bus_wdata[0] && !start_q && mode_q && fsm_idle;
    assign clr_done = start_wr && !bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            start_q  <= 1'b0;
            op_q     <= '0;
            rowsel_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFF_ACCESS: mode_q   <= bus_wdata[0];
                OFF_START:  start_q  <= bus_wdata[0];
                OFF_OP:     op_q     <= bus_wdata[OP_W-1:0];
                OFF_ROWSEL: rowsel_q <= bus_wdata[ROWA_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else if (bus_wr) begin
            for (int w = 0; w < ROW_WORDS; w++) begin
                if (bus_addr == wr_word_off(w)) wd_q[w*WORD_W +: WORD_W] <= bus_wdata;
            end
        end
    end

    assign rd_ext = (2*WORD_W)'(rd_row);
    assign wd_ext = (2*WORD_W)'(wd_q);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_ACCESS: bus_rdata = {{(WORD_W-1){1'b0}}, mode_q};
            OFF_OP:     bus_rdata = {{(WORD_W-OP_W){1'b0}}, op_q};
            OFF_START:  bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
            OFF_STATUS: bus_rdata = {{(WORD_W-STAT_W){1'b0}}, status};
            OFF_ROWSEL: bus_rdata = {{(WORD_W-ROWA_W){1'b0}}, rowsel_q};
            OFF_RDW0:   bus_rdata = rd_ext[WORD_W-1:0];
            OFF_RDW1:   bus_rdata = rd_ext[2*WORD_W-1:WORD_W];
            OFF_WRW0:   bus_rdata = wd_ext[WORD_W-1:0];
            OFF_WRW1:   bus_rdata = wd_ext[2*WORD_W-1:WORD_W];
            default:    bus_rdata = '0;
        endcase
    end

    assign access_en = mode_q;
    assign op_code   = op_q;
    assign row_addr  = rowsel_q;
    assign wr_row    = wd_q;

    AST_NO_LAUNCH_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !clr_done) |=> !launch) else $error("start held high relaunched"); // R3
endmodule

// File: rtl/otp_unlock_chk.sv
module otp_unlock_chk
    import otp_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [WORD_W-1:0] key_in,
    input  logic              relock,
    output logic              unlocked,
    output logic              key_done
);
    logic [1:0] step_q;
    logic       unlocked_q;
    logic       key_match;

    assign key_match = (key_in == unlock_key(step_q));
    assign key_done  = step_en && key_match && (step_q == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q     <= 2'd0;
            unlocked_q <= 1'b0;
        end else if (relock) begin
            step_q     <= 2'd0;
            unlocked_q <= 1'b0;
        end else if (step_en) begin
            if (!key_match) begin
                step_q <= 2'd0;
            end else if (step_q == 2'd3) begin
                step_q     <= 2'd0;
                unlocked_q <= 1'b1;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    assign unlocked = unlocked_q;

    AST_UNLOCK_AFTER_FULL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_q) |-> ($past(step_q) == 2'd3 && $past(step_en))) else $error("unlock without key"); // R6
    AST_MISMATCH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !key_match && !relock) |=> (step_q == 2'd0)) else $error("bad key kept progress"); // R7
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int ROWS     = 16,
    parameter int ROW_BITS = 64,
    localparam int IDX_W   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    idx,
    output logic [ROW_BITS-1:0] rd_data,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] wr_bits
);
    logic [ROW_BITS-1:0] mem_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en) begin
            mem_q[idx] <= mem_q[idx] | wr_bits;
        end
    end

    assign rd_data = mem_q[idx];

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        AST_FUSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(mem_q[r]) & ~mem_q[r]) == '0)) else $error("fused bit cleared"); // R9
    end
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_ctrl_pkg::*;
#(
    parameter int ROW_WORDS   = 2,
    parameter int ROWS        = 16,
    parameter int PROG_CYCLES = 64,
    parameter int READ_CYCLES = 3,
    localparam int ROW_BITS   = ROW_WORDS * WORD_W,
    localparam int IDX_W      = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                clr_done,
    input  logic [OP_W-1:0]     op_in,
    input  logic [IDX_W-1:0]    idx_in,
    input  logic [ROW_BITS-1:0] wdata_in,
    output logic                idle,
    output logic [STAT_W-1:0]   status,
    output logic [ROW_BITS-1:0] rd_row,
    output logic [IDX_W-1:0]    arr_idx,
    input  logic [ROW_BITS-1:0] arr_rdata,
    output logic                arr_wr_en,
    output logic [ROW_BITS-1:0] arr_wr_bits,
    output logic                key_step_en,
    output logic [WORD_W-1:0]   key_value,
    output logic                relock,
    input  logic                unlocked,
    input  logic                key_done
);
    localparam int CNT_W = $clog2(PROG_CYCLES + READ_CYCLES + 2);

    fsm_state_t          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    lat_q;
    logic [OP_W-1:0]     op_q;
    logic [IDX_W-1:0]    idx_q;
    logic [ROW_BITS-1:0] data_q;
    logic [ROW_BITS-1:0] rd_q;
    logic                done_q;
    logic                ok_q;
    logic                waiting;
    logic                finish;

    assign waiting = (state_q == ST_RD_WAIT) || (state_q == ST_PG_WAIT) || (state_q == ST_CTL_WAIT);
    assign finish  = (state_q == ST_FINISH);
    assign idle    = (state_q == ST_IDLE);

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    if (op_in == OP_READ)         state_d = ST_RD_WAIT;
                    else if (op_in == OP_PROGRAM) state_d = ST_PG_WAIT;
                    else                          state_d = ST_CTL_WAIT;
                end
            end
            ST_RD_WAIT, ST_PG_WAIT, ST_CTL_WAIT: begin
                if (cnt_q == '0) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin : outputs
        if (!rst_n) begin
            cnt_q  <= '0;
            lat_q  <= '0;
            op_q   <= '0;
            idx_q  <= '0;
            data_q <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            if (idle && launch) begin
                op_q   <= op_in;
                idx_q  <= idx_in;
                data_q <= wdata_in;
                done_q <= 1'b0;
                lat_q  <= '0;
                if (op_in == OP_READ)         cnt_q <= CNT_W'(READ_CYCLES - 1);
                else if (op_in == OP_PROGRAM) cnt_q <= CNT_W'(PROG_CYCLES - 1);
                else                          cnt_q <= '0;
            end else if (waiting) begin
                lat_q <= lat_q + 1'b1;
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            end

            if (finish) begin
                done_q <= 1'b1;
                case (op_q)
                    OP_READ:    rd_q <= arr_rdata;
                    OP_UNLOCK:  ok_q <= unlocked | key_done;
                    OP_PROGRAM: ok_q <= unlocked;
                    OP_RELOCK:  ok_q <= 1'b1;
                    default: ;
                endcase
            end else if (clr_done) begin
                done_q <= 1'b0;
            end
        end
    end

    assign status      = {ok_q, done_q, !idle};
    assign rd_row      = rd_q;
    assign arr_idx     = idx_q;
    assign arr_wr_en   = finish && (op_q == OP_PROGRAM) && unlocked;
    assign arr_wr_bits = data_q;
    assign key_step_en = finish && (op_q == OP_UNLOCK);
    assign key_value   = data_q[WORD_W-1:0];
    assign relock      = finish && (op_q == OP_RELOCK);

    AST_PROG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && op_q == OP_PROGRAM) |-> (lat_q == CNT_W'(PROG_CYCLES))) else $error("program latency"); // R10
    AST_LOCKED_PROG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && op_q == OP_PROGRAM && !unlocked) |=> (!ok_q && done_q)) else $error("locked program"); // R8
    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> idle) else $error("done while busy"); // R3
    AST_RELOCK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> (ok_q && !unlocked)) else $error("relock result"); // R11
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_ctrl_pkg::*;
#(
    parameter int ROW_WORDS   = 2,
    parameter int ROWS        = 16,
    parameter int PROG_CYCLES = 64,
    parameter int READ_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int ROW_BITS = ROW_WORDS * WORD_W;
    localparam int IDX_W    = $clog2(ROWS);

    logic                access_en, launch, clr_done, fsm_idle;
    logic [OP_W-1:0]     op_code;
    logic [ROWA_W-1:0]   row_addr;
    logic [ROW_BITS-1:0] wr_row, rd_row, arr_rdata, arr_wr_bits;
    logic [STAT_W-1:0]   status;
    logic [IDX_W-1:0]    arr_idx;
    logic                arr_wr_en, key_step_en, relock, unlocked, key_done;
    logic [WORD_W-1:0]   key_value;
    logic                unused_addr_hi;

    assign unused_addr_hi = ^row_addr[ROWA_W-1:IDX_W];

    otp_regfile #(.ROW_WORDS(ROW_WORDS)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fsm_idle(fsm_idle),
        .status(status), .rd_row(rd_row), .access_en(access_en), .launch(launch),
        .clr_done(clr_done), .op_code(op_code), .row_addr(row_addr), .wr_row(wr_row)
    );

    otp_cmd_fsm #(
        .ROW_WORDS(ROW_WORDS), .ROWS(ROWS),
        .PROG_CYCLES(PROG_CYCLES), .READ_CYCLES(READ_CYCLES)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .clr_done(clr_done),
        .op_in(op_code), .idx_in(row_addr[IDX_W-1:0]), .wdata_in(wr_row),
        .idle(fsm_idle), .status(status), .rd_row(rd_row), .arr_idx(arr_idx),
        .arr_rdata(arr_rdata), .arr_wr_en(arr_wr_en), .arr_wr_bits(arr_wr_bits),
        .key_step_en(key_step_en), .key_value(key_value), .relock(relock),
        .unlocked(unlocked), .key_done(key_done)
    );

    otp_unlock_chk key_i (
        .clk(clk), .rst_n(rst_n), .step_en(key_step_en), .key_in(key_value),
        .relock(relock), .unlocked(unlocked), .key_done(key_done)
    );

    otp_fuse_array #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) fuse_i (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx), .rd_data(arr_rdata),
        .wr_en(arr_wr_en), .wr_bits(arr_wr_bits)
    );

    AST_ACCESS_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_en && fsm_idle) |=> fsm_idle) else $error("launch with access off"); // R2
    AST_START_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_START && !bus_wdata[0] && fsm_idle) |=> !status[1]) else $error("done kept"); // R3
endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
    localparam int PROG_CYC = 64;
    localparam int READ_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    otp_fuse_ctrl #(.ROW_WORDS(2), .ROWS(16), .PROG_CYCLES(PROG_CYC), .READ_CYCLES(READ_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_cmd(input logic [5:0] op, input logic [15:0] row, input logic [31:0] d0,
                           input logic [31:0] d1, output int cyc, output logic [31:0] st,
                           output logic [31:0] busy_seen);
        logic [31:0] s;
        wr(8'h04, {26'd0, op});
        wr(8'h28, {16'd0, row});
        wr(8'h2C, d0);
        wr(8'h64, d1);
        wr(8'h08, 32'd1);
        cyc = 0;
        busy_seen = 0;
        s = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            rd(8'h0C, s);
            if (cyc == 1) busy_seen = s;
            if (s[1]) break;
        end
        st = s;
        wr(8'h08, 32'd0);
    endtask

    task automatic read_row(input logic [15:0] row, output logic [31:0] w0, output logic [31:0] w1);
        int c; logic [31:0] s, b;
        run_cmd(6'h00, row, 32'd0, 32'd0, c, s, b);
        rd(8'h10, w0);
        rd(8'h5C, w1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h0C, v); check("R1 status", v, 32'h0);
        rd(8'h08, v); check("R1 start", v, 32'h0);
        rd(8'h04, v); check("R1 opcode", v, 32'h0);
        rd(8'h10, v); check("R1 rd word0", v, 32'h0);
        rd(8'h5C, v); check("R1 rd word1", v, 32'h0);
    endtask

    task automatic t_access_gate;
        logic [31:0] v;
        wr(8'h04, 32'h0);
        wr(8'h08, 32'd1);
        repeat (10) @(negedge clk);
        rd(8'h0C, v); check("R2 no launch with access off", v, 32'h0);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'd1);
    endtask

    task automatic t_field_mask;
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFC8);
        rd(8'h04, v); check("R4 opcode masked", v, 32'h08);
        wr(8'h28, 32'hABCD_1234);
        rd(8'h28, v); check("R4 row masked", v, 32'h1234);
    endtask

    task automatic t_read_blank;
        logic [31:0] v, s;
        int c;
        wr(8'h04, 32'h0);
        wr(8'h28, 32'd3);
        wr(8'h08, 32'd1);
        c = 0; s = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); c++;
            @(negedge clk); rd(8'h0C, s);
            if (s[1]) break;
        end
        check("R5 read latency", c, READ_CYC + 1);
        check("R3 status done only", s, 32'h2);
        wr(8'h08, 32'd1);
        @(negedge clk);
        rd(8'h0C, v); check("R3 start held high no relaunch", v, 32'h2);
        rd(8'h10, v); check("R1 blank row word0", v, 32'h0);
        wr(8'h08, 32'd0);
        rd(8'h0C, v); check("R3 start clear drops done", v, 32'h0);
    endtask

    task automatic t_locked_prog;
        int c; logic [31:0] s, b, w0, w1;
        run_cmd(6'h08, 16'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c, s, b);
        check("R8 locked program status", s, 32'h2);
        read_row(16'd5, w0, w1);
        check("R8 row unchanged w0", w0, 32'h0);
        check("R8 row unchanged w1", w1, 32'h0);
    endtask

    task automatic t_bad_unlock;
        int c; logic [31:0] s, b, w0, w1;
        run_cmd(6'h02, 16'd0, 32'hF, 32'h0, c, s, b);
        run_cmd(6'h02, 16'd0, 32'h4, 32'h0, c, s, b);
        run_cmd(6'h02, 16'd0, 32'h9, 32'h0, c, s, b);
        run_cmd(6'h02, 16'd0, 32'h8, 32'h0, c, s, b);
        run_cmd(6'h02, 16'd0, 32'hD, 32'h0, c, s, b);
        check("R7 broken key stays locked", s, 32'h2);
        run_cmd(6'h08, 16'd7, 32'h5555, 32'h0, c, s, b);
        check("R7 program after broken key rejected", s, 32'h2);
        read_row(16'd7, w0, w1);
        check("R7 row untouched", w0, 32'h0);
    endtask

    task automatic t_unlock;
        int c; logic [31:0] s, b;
        logic [31:0] key [4];
        key[0] = 32'hF; key[1] = 32'h4; key[2] = 32'h8; key[3] = 32'hD;
        for (int k = 0; k < 4; k++) begin
            run_cmd(6'h02, 16'd0, key[k], 32'h0, c, s, b);
            check("R6 unlock step latency", c, 2);
            check("R6 unlock step status", s, (k == 3) ? 32'h6 : 32'h2);
        end
    endtask

    task automatic t_program;
        int c; logic [31:0] s, b, w0, w1;
        run_cmd(6'h08, 16'd5, 32'h0000_00F0, 32'h1234_0000, c, s, b);
        check("R10 program latency", c, PROG_CYC + 1);
        check("R10 busy during program", b, 32'h4 | 32'h1);
        check("R9 program ok", s, 32'h6);
        read_row(16'd5, w0, w1);
        check("R9 row word0", w0, 32'h0000_00F0);
        check("R9 row word1", w1, 32'h1234_0000);
        run_cmd(6'h08, 16'd5, 32'h0000_000F, 32'h0, c, s, b);
        read_row(16'd5, w0, w1);
        check("R9 OR word0", w0, 32'h0000_00FF);
        check("R9 OR keeps word1", w1, 32'h1234_0000);
    endtask

    task automatic t_relock;
        int c; logic [31:0] s, b, w0, w1;
        run_cmd(6'h03, 16'd0, 32'h0, 32'h0, c, s, b);
        check("R11 relock reports ok", s, 32'h6);
        run_cmd(6'h08, 16'd6, 32'hAA, 32'hAA, c, s, b);
        check("R11 program after relock rejected", s, 32'h2);
        read_row(16'd6, w0, w1);
        check("R11 row stays blank", w0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_access_gate();
        t_field_mask();
        t_read_blank();
        t_locked_prog();
        t_bad_unlock();
        t_unlock();
        t_program();
        t_relock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule